// File: doc/BRIEF.md
# Eight-Level Prioritized Frame Queue Scheduler

This block is one scheduling channel for a packet engine. It stores frame descriptors in per-queue FIFOs (frame queues) and keeps eight priority levels, each an ordered list of the frame queues that currently hold frames. Producers push a descriptor tagged with its frame queue number and a priority level. Consumers raise a request and receive, one cycle later, the oldest descriptor of the frame queue at the head of the most urgent non-empty level.

Frame queues of equal priority take turns. After a dequeue, a frame queue that still holds frames goes to the back of its level, and it leaves the level when its last frame is taken. The channel runs in one of two modes. When bound to one consumer, only that consumer is served. When shared by a group, a round-robin arbiter serves one requester per cycle. If a frame queue's storage is full, a back-pressure output tells the producer to hold the descriptor, and nothing is lost.

Top module: `fqs_sched`

## Requirements
- R1: After reset `rspAck` and `rspValid` are 0, `enqStall` is 0 while no enqueue is offered, and every frame queue and priority level is empty.
- R2: A dequeue always serves the lowest-numbered non-empty priority level. Level 0 is the most urgent and level 7 the least.
- R3: Descriptors of one frame queue leave in the order in which they were accepted.
- R4: A frame queue joins the back of its level when it receives a frame while empty. After a dequeue it goes to the back of its level if it still holds a frame, and it leaves the level if it does not. Frame queues of one level are therefore served in rotation.
- R5: A frame queue's level is the `enqWq` given with the frame that made it non-empty. The `enqWq` of later frames is ignored until the queue drains. After it drains, the next frame chooses the level again.
- R6: `enqStall` is 1 in the same cycle in which `enqValid` is 1 and the target frame queue already holds FQ_DEPTH frames, counted before any dequeue of that cycle. A stalled descriptor is not stored.
- R7: A request granted at a clock edge produces, after that edge, a one-cycle one-hot `rspAck` for the granted consumer. With it come `rspValid`, `rspDesc`, `rspFq` and `rspWq` (the level that was served).
- R8: A granted request on a channel with no stored frames gives `rspAck` with `rspValid` = 0.
- R9: With `poolMode` = 0 only consumer `dedCons` is served. Requests from any other consumer get no `rspAck` and remove no frame.
- R10: With `poolMode` = 1, at most one consumer is acknowledged per cycle. The search starts at the consumer after the last one granted, and index NUM_CONS-1 wraps to 0.
- R11: An enqueue and a dequeue in the same cycle both take effect. This holds when they target the same frame queue: a queue dequeued in the cycle it receives a frame stays on its level and moves to the back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| poolMode | input | 1 | 1: shared by all consumers; 0: bound to `dedCons` |
| dedCons | input | CONS_W | Consumer served when `poolMode` is 0 |
| enqValid | input | 1 | Descriptor offered |
| enqFq | input | FQ_W | Target frame queue |
| enqWq | input | 3 | Priority level, used only when the frame queue is empty |
| enqDesc | input | DESC_W | Frame descriptor |
| enqStall | output | 1 | Target frame queue full; hold the descriptor |
| deqReq | input | NUM_CONS | One dequeue request per consumer |
| rspAck | output | NUM_CONS | One-hot: consumer served this cycle |
| rspValid | output | 1 | A descriptor accompanies `rspAck` |
| rspDesc | output | DESC_W | Dequeued descriptor |
| rspFq | output | FQ_W | Frame queue it came from |
| rspWq | output | 3 | Level that was served |

## Verification
Several properties are checked on every cycle. Any dequeue must pick a non-empty level with no non-empty level above it. No write may land in a full frame queue. At most one consumer is acknowledged per cycle, and in bound mode only the bound one. A valid response never appears without an acknowledge. Frame ordering within a queue, rotation among queues of a level, the level latched at a queue's first frame, the arbiter's rotation and same-cycle enqueue/dequeue interplay all concern contents across many cycles. Only the bench's scenarios and its long mixed sweep against a queue model can show them.

// File: rtl/fqs_pkg.sv
package fqs_pkg;
  localparam int WQ_COUNT = 8;
  localparam int WQ_W = 3;

  typedef logic [WQ_W-1:0] wq_idx_t;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic    enqWrite;   // store enqDesc into enqFq
    logic    enqNewFq;   // enqFq was empty: link it to the back of enqWq
    logic    deqPop;     // pop head frame queue of deqWq
    logic    deqRotate;  // popped queue still holds frames: move it to the back
    wq_idx_t deqWq;      // level being served
  } ctrl_strobe_t;
endpackage

// File: rtl/fqs_rr_arb.sv
module fqs_rr_arb #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic             anyGrant
);
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] grantIdx;

  always_comb begin
    int cand;
    grant    = '0;
    grantIdx = '0;
    anyGrant = 1'b0;
    for (int k = 0; k < N; k++) begin
      cand = (int'(ptr) + k) % N;
      if (!anyGrant && req[cand]) begin
        anyGrant    = 1'b1;
        grant[cand] = 1'b1;
        grantIdx    = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (anyGrant) ptr <= (grantIdx == IDX_W'(N-1)) ? '0 : grantIdx + 1'b1;
  end
endmodule

// File: rtl/fqs_ctrl.sv
module fqs_ctrl
  import fqs_pkg::*;
#(
  parameter int NUM_FQ   = 8,
  parameter int FQ_DEPTH = 4,
  parameter int NUM_CONS = 4,
  parameter int FQ_W     = 3,
  parameter int CNT_W    = 3,
  parameter int CONS_W   = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               poolMode,
  input  logic [CONS_W-1:0]                  dedCons,
  input  logic                               enqValid,
  input  logic [FQ_W-1:0]                    enqFq,
  input  logic [NUM_CONS-1:0]                deqReq,
  input  logic [WQ_COUNT-1:0]                wqBusy,
  input  logic [WQ_COUNT-1:0][FQ_W-1:0]      wqHead,
  input  logic [NUM_FQ-1:0][CNT_W-1:0]       fqCnt,
  output ctrl_strobe_t                       stb,
  output logic                               enqStall,
  output logic [NUM_CONS-1:0]                rspAck
);
  logic [NUM_CONS-1:0] maskedReq;
  logic [NUM_CONS-1:0] grant;
  logic                anyGrant;
  wq_idx_t             selWq;
  logic [FQ_W-1:0]     headFq;
  logic [CNT_W-1:0]    headCnt;
  logic [CNT_W-1:0]    enqCnt;
  logic                enqFull;
  logic                sameFq;

  // Bound mode masks every requester but the bound consumer
  assign maskedReq = poolMode ? deqReq : (deqReq & (NUM_CONS'(1) << dedCons));

  fqs_rr_arb #(.N(NUM_CONS), .IDX_W(CONS_W)) u_arb (
    .clk      (clk),
    .rstN     (rstN),
    .req      (maskedReq),
    .grant    (grant),
    .anyGrant (anyGrant)
  );

  // Strict priority: lowest-numbered busy level wins
  always_comb begin
    selWq = '0;
    for (int w = WQ_COUNT - 1; w >= 0; w--) begin
      if (wqBusy[w]) selWq = WQ_W'(w);
    end
  end

  assign headFq   = wqHead[selWq];
  assign headCnt  = fqCnt[headFq];
  assign enqCnt   = fqCnt[enqFq];
  assign enqFull  = (enqCnt == CNT_W'(FQ_DEPTH));
  assign enqStall = enqValid && enqFull;

  always_comb begin
    stb.enqWrite  = enqValid && !enqFull;
    stb.enqNewFq  = stb.enqWrite && (enqCnt == '0);
    stb.deqPop    = anyGrant && (|wqBusy);
    stb.deqWq     = selWq;
    sameFq        = stb.enqWrite && (enqFq == headFq);
    stb.deqRotate = stb.deqPop && ((headCnt > CNT_W'(1)) || sameFq);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspAck <= '0;
    else       rspAck <= grant;
  end

  // R10: never more than one consumer acknowledged
  p_ack_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspAck));

  // R9: in bound mode only the bound consumer is acknowledged
  p_bound_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((|rspAck) && !$past(poolMode)) |-> (rspAck == (NUM_CONS'(1) << $past(dedCons))));
endmodule

// File: rtl/fqs_datapath.sv
module fqs_datapath
  import fqs_pkg::*;
#(
  parameter int NUM_FQ   = 8,
  parameter int FQ_DEPTH = 4,
  parameter int DESC_W   = 16,
  parameter int FQ_W     = 3,
  parameter int CNT_W    = 3,
  parameter int PTR_W    = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctrl_strobe_t                       stb,
  input  logic [FQ_W-1:0]                    enqFq,
  input  wq_idx_t                            enqWq,
  input  logic [DESC_W-1:0]                  enqDesc,
  output logic [WQ_COUNT-1:0]                wqBusy,
  output logic [WQ_COUNT-1:0][FQ_W-1:0]      wqHead,
  output logic [NUM_FQ-1:0][CNT_W-1:0]       fqCnt,
  output logic                               rspValid,
  output logic [DESC_W-1:0]                  rspDesc,
  output logic [FQ_W-1:0]                    rspFq,
  output wq_idx_t                            rspWq
);
  localparam int SLOTS  = NUM_FQ * FQ_DEPTH;
  localparam int ADDR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [DESC_W-1:0] descMem [SLOTS];
  logic [NUM_FQ-1:0][PTR_W-1:0] rdPtrV, wrPtrV;

  // Level lists: head, tail, busy per level, link per frame queue
  logic [WQ_COUNT-1:0][FQ_W-1:0] headR, tailR, nHead, nTail;
  logic [WQ_COUNT-1:0]           busyR, nBusy;
  logic [NUM_FQ-1:0][FQ_W-1:0]   linkR, nLink;

  logic [FQ_W-1:0]   popFq;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  assign popFq  = headR[stb.deqWq];
  assign wrAddr = ADDR_W'(int'(enqFq) * FQ_DEPTH + int'(wrPtrV[enqFq]));
  assign rdAddr = ADDR_W'(int'(popFq) * FQ_DEPTH + int'(rdPtrV[popFq]));

  // Per frame queue circular pointers and occupancy
  for (genvar f = 0; f < NUM_FQ; f++) begin : g_fq
    logic [PTR_W-1:0] rdP, wrP;
    logic [CNT_W-1:0] cnt;
    logic             pushHere, popHere;

    assign pushHere = stb.enqWrite && (enqFq == FQ_W'(f));
    assign popHere  = stb.deqPop && (popFq == FQ_W'(f));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdP <= '0;
        wrP <= '0;
        cnt <= '0;
      end else begin
        if (pushHere) wrP <= (wrP == PTR_W'(FQ_DEPTH-1)) ? '0 : wrP + 1'b1;
        if (popHere)  rdP <= (rdP == PTR_W'(FQ_DEPTH-1)) ? '0 : rdP + 1'b1;
        if (pushHere && !popHere)      cnt <= cnt + 1'b1;
        else if (popHere && !pushHere) cnt <= cnt - 1'b1;
      end
    end

    assign rdPtrV[f] = rdP;
    assign wrPtrV[f] = wrP;
    assign fqCnt[f]  = cnt;
  end

  always_ff @(posedge clk) begin
    if (stb.enqWrite) descMem[wrAddr] <= enqDesc;
  end

  // Next state of the level lists: pop/rotate first, then append a new queue
  always_comb begin
    nHead = headR;
    nTail = tailR;
    nBusy = busyR;
    nLink = linkR;
    if (stb.deqPop) begin
      if (headR[stb.deqWq] == tailR[stb.deqWq]) begin
        if (!stb.deqRotate) nBusy[stb.deqWq] = 1'b0;
      end else begin
        nHead[stb.deqWq] = linkR[popFq];
        if (stb.deqRotate) begin
          nLink[tailR[stb.deqWq]] = popFq;
          nTail[stb.deqWq]        = popFq;
        end
      end
    end
    if (stb.enqNewFq) begin
      if (!nBusy[enqWq]) begin
        nHead[enqWq] = enqFq;
        nTail[enqWq] = enqFq;
        nBusy[enqWq] = 1'b1;
      end else begin
        nLink[nTail[enqWq]] = enqFq;
        nTail[enqWq]        = enqFq;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headR <= '0;
      tailR <= '0;
      busyR <= '0;
      linkR <= '0;
    end else begin
      headR <= nHead;
      tailR <= nTail;
      busyR <= nBusy;
      linkR <= nLink;
    end
  end

  assign wqBusy = busyR;
  assign wqHead = headR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspDesc  <= '0;
      rspFq    <= '0;
      rspWq    <= '0;
    end else begin
      rspValid <= stb.deqPop;
      if (stb.deqPop) begin
        rspDesc <= descMem[rdAddr];
        rspFq   <= popFq;
        rspWq   <= stb.deqWq;
      end
    end
  end

  // R6: control never writes into a full frame queue
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.enqWrite |-> (fqCnt[enqFq] < CNT_W'(FQ_DEPTH)));

  // R2: a served level is busy and its head queue holds a frame
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.deqPop |-> (busyR[stb.deqWq] && (fqCnt[popFq] != '0)));

  // R2: no busy level above the served one
  p_strict_prio_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.deqPop |-> ((busyR & ((WQ_COUNT'(1) << stb.deqWq) - WQ_COUNT'(1))) == '0));
endmodule

// File: rtl/fqs_sched.sv
module fqs_sched
  import fqs_pkg::*;
#(
  parameter int NUM_FQ   = 8,
  parameter int FQ_DEPTH = 4,
  parameter int DESC_W   = 16,
  parameter int NUM_CONS = 4,
  localparam int FQ_W    = (NUM_FQ > 1) ? $clog2(NUM_FQ) : 1,
  localparam int CNT_W   = $clog2(FQ_DEPTH + 1),
  localparam int PTR_W   = (FQ_DEPTH > 1) ? $clog2(FQ_DEPTH) : 1,
  localparam int CONS_W  = (NUM_CONS > 1) ? $clog2(NUM_CONS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                poolMode,
  input  logic [CONS_W-1:0]   dedCons,
  input  logic                enqValid,
  input  logic [FQ_W-1:0]     enqFq,
  input  logic [2:0]          enqWq,
  input  logic [DESC_W-1:0]   enqDesc,
  output logic                enqStall,
  input  logic [NUM_CONS-1:0] deqReq,
  output logic [NUM_CONS-1:0] rspAck,
  output logic                rspValid,
  output logic [DESC_W-1:0]   rspDesc,
  output logic [FQ_W-1:0]     rspFq,
  output logic [2:0]          rspWq
);
  ctrl_strobe_t                  stb;
  logic [WQ_COUNT-1:0]           wqBusy;
  logic [WQ_COUNT-1:0][FQ_W-1:0] wqHead;
  logic [NUM_FQ-1:0][CNT_W-1:0]  fqCnt;

  fqs_ctrl #(
    .NUM_FQ(NUM_FQ), .FQ_DEPTH(FQ_DEPTH), .NUM_CONS(NUM_CONS),
    .FQ_W(FQ_W), .CNT_W(CNT_W), .CONS_W(CONS_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .poolMode (poolMode),
    .dedCons  (dedCons),
    .enqValid (enqValid),
    .enqFq    (enqFq),
    .deqReq   (deqReq),
    .wqBusy   (wqBusy),
    .wqHead   (wqHead),
    .fqCnt    (fqCnt),
    .stb      (stb),
    .enqStall (enqStall),
    .rspAck   (rspAck)
  );

  fqs_datapath #(
    .NUM_FQ(NUM_FQ), .FQ_DEPTH(FQ_DEPTH), .DESC_W(DESC_W),
    .FQ_W(FQ_W), .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .enqFq    (enqFq),
    .enqWq    (enqWq),
    .enqDesc  (enqDesc),
    .wqBusy   (wqBusy),
    .wqHead   (wqHead),
    .fqCnt    (fqCnt),
    .rspValid (rspValid),
    .rspDesc  (rspDesc),
    .rspFq    (rspFq),
    .rspWq    (rspWq)
  );

  // R8/R7: a valid descriptor only travels with an acknowledge
  p_valid_has_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (|rspAck));
endmodule

// File: tb/fqs_sched_test.sv
module fqs_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NFQ   = 8;
  localparam int DEPTH = 4;
  localparam int DW    = 16;
  localparam int NC    = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          poolMode = 1'b1;
  logic [1:0]    dedCons = '0;
  logic          enqValid = 1'b0;
  logic [2:0]    enqFq = '0;
  logic [2:0]    enqWq = '0;
  logic [DW-1:0] enqDesc = '0;
  logic          enqStall;
  logic [NC-1:0] deqReq = '0;
  logic [NC-1:0] rspAck;
  logic          rspValid;
  logic [DW-1:0] rspDesc;
  logic [2:0]    rspFq;
  logic [2:0]    rspWq;

  fqs_sched #(.NUM_FQ(NFQ), .FQ_DEPTH(DEPTH), .DESC_W(DW), .NUM_CONS(NC)) uut (
    .clk(clk), .rstN(rstN), .poolMode(poolMode), .dedCons(dedCons),
    .enqValid(enqValid), .enqFq(enqFq), .enqWq(enqWq), .enqDesc(enqDesc),
    .enqStall(enqStall), .deqReq(deqReq), .rspAck(rspAck), .rspValid(rspValid),
    .rspDesc(rspDesc), .rspFq(rspFq), .rspWq(rspWq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model: queues of descriptors and ordered lists of queues
  logic [DW-1:0] fqFrames [NFQ][$];
  int            wqList   [8][$];
  int            rrPtr = 0;
  logic [DW-1:0] nextDesc = 16'h0100;
  logic [15:0]   lfsr = 16'hACE1;

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int modelTotal();
    int t = 0;
    for (int f = 0; f < NFQ; f++) t += fqFrames[f].size();
    return t;
  endfunction

  // One clock: drive at the falling edge, predict, sample at the next falling edge
  task automatic cycle(string tag, bit ev, int fq, int wq, logic [NC-1:0] req);
    bit expStall, accepted, wasEmpty, gAny, expValid;
    int g, expFq, expWq;
    logic [DW-1:0] expDesc, d;
    d = nextDesc;
    nextDesc = nextDesc + 1'b1;
    enqValid = ev; enqFq = 3'(fq); enqWq = 3'(wq); enqDesc = d; deqReq = req;
    #1;
    expStall = ev && (fqFrames[fq].size() == DEPTH);
    check(tag, "enqStall", enqStall, expStall);
    gAny = 0; g = 0;
    if (poolMode) begin
      for (int k = 0; k < NC; k++) begin
        int c = (rrPtr + k) % NC;
        if (!gAny && req[c]) begin gAny = 1; g = c; end
      end
    end else if (req[dedCons]) begin
      gAny = 1; g = int'(dedCons);
    end
    if (gAny) rrPtr = (g + 1) % NC;
    accepted = ev && !expStall;
    wasEmpty = accepted && (fqFrames[fq].size() == 0);
    expValid = 0; expFq = 0; expWq = 0; expDesc = '0;
    if (gAny) begin
      for (int w = 0; w < 8; w++) begin
        if (!expValid && wqList[w].size() > 0) begin
          expValid = 1; expWq = w;
          expFq = wqList[w].pop_front();
          expDesc = fqFrames[expFq].pop_front();
        end
      end
    end
    if (accepted) fqFrames[fq].push_back(d);
    if (expValid && fqFrames[expFq].size() > 0) wqList[expWq].push_back(expFq);
    if (wasEmpty) wqList[wq].push_back(fq);
    @(posedge clk);
    @(negedge clk);
    check(tag, "rspAck", rspAck, gAny ? (longint'(1) << g) : 0);
    check(tag, "rspValid", rspValid, expValid);
    if (expValid) begin
      check(tag, "rspDesc", rspDesc, expDesc);
      check(tag, "rspFq", rspFq, expFq);
      check(tag, "rspWq", rspWq, expWq);
    end
    enqValid = 0; deqReq = '0;
  endtask

  task automatic drain(string tag);
    int guard = 0;
    while (modelTotal() > 0 && guard < 200) begin
      cycle(tag, 0, 0, 0, poolMode ? 4'b1111 : (4'b0001 << dedCons));
      guard++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "rspAck", rspAck, 0);
    check("R1", "rspValid", rspValid, 0);
    check("R1", "enqStall", enqStall, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "rspAck after release", rspAck, 0);

    // R8: empty channel gives an acknowledge without data
    cycle("R8", 0, 0, 0, 4'b0001);

    // R2: one queue per level filled from least urgent upward, served from level 0
    for (int w = 7; w >= 0; w--) cycle("R2", 1, w, w, 4'b0000);
    for (int i = 0; i < 8; i++) cycle("R2", 0, 0, 0, 4'b0001);
    cycle("R8", 0, 0, 0, 4'b0010);

    // R6 and R3: fill a queue, overflow stalls, then order is kept
    for (int i = 0; i < 6; i++) cycle("R6", 1, 2, 5, 4'b0000);
    cycle("R6", 1, 2, 5, 4'b0001);   // full counted before the pop: still stalls
    cycle("R6", 1, 2, 5, 4'b0000);   // room again: accepted
    for (int i = 0; i < 4; i++) cycle("R3", 0, 0, 0, 4'b0100);
    drain("R3");

    // R4: three queues on one level rotate
    for (int r = 0; r < 2; r++)
      for (int f = 0; f < 3; f++) cycle("R4", 1, f, 3, 4'b0000);
    for (int i = 0; i < 6; i++) cycle("R4", 0, 0, 0, 4'b1000);

    // R5: level latched from the first frame, later tags ignored
    cycle("R5", 1, 5, 6, 4'b0000);
    cycle("R5", 1, 5, 1, 4'b0000);
    cycle("R5", 1, 6, 4, 4'b0000);
    for (int i = 0; i < 3; i++) cycle("R5", 0, 0, 0, 4'b0001);
    cycle("R5", 1, 6, 2, 4'b0000);
    cycle("R5", 1, 5, 1, 4'b0000);   // drained queue picks a new level
    cycle("R5", 0, 0, 0, 4'b0001);
    drain("R5");

    // R11: enqueue and dequeue of the same and of a new queue in one cycle
    cycle("R11", 1, 3, 0, 4'b0000);
    cycle("R11", 1, 3, 0, 4'b0001);  // pop last frame while adding one: stays
    cycle("R11", 1, 4, 0, 4'b0001);  // pop last of queue 3 while queue 4 joins
    cycle("R11", 1, 4, 0, 4'b0001);
    drain("R11");

    // R9: bound mode ignores other consumers
    poolMode = 1'b0; dedCons = 2'd2;
    cycle("R9", 1, 1, 2, 4'b0000);
    cycle("R9", 0, 0, 0, 4'b1011);
    cycle("R9", 0, 0, 0, 4'b1111);
    cycle("R9", 0, 0, 0, 4'b1011);

    // R10: shared mode rotates among simultaneous requesters
    poolMode = 1'b1;
    for (int i = 0; i < 4; i++) cycle("R10", 1, i, 7 - i, 4'b0000);
    for (int i = 0; i < 6; i++) cycle("R10", 0, 0, 0, 4'b1111);
    cycle("R10", 0, 0, 0, 4'b1010);
    cycle("R10", 0, 0, 0, 4'b1010);

    // R7: long mixed traffic in both modes
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 500 == 0) begin
        poolMode = ~poolMode;
        dedCons  = 2'(i / 500);
      end
      cycle("R7", lfsr[0] | lfsr[1], lfsr[4] ? int'(lfsr[3:2]) : int'(lfsr[7:5]),
            int'(lfsr[10:8]), 4'(lfsr[14:11] & {4{lfsr[15] | lfsr[0]}}));
    end
    drain("R7");
    cycle("R8", 0, 0, 0, poolMode ? 4'b0001 : (4'b0001 << dedCons));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule